// File: doc/BRIEF.md
# Timer-Paced Peripheral Bridge

This block connects a host processor to as many as four command-driven peripherals through two byte-wide host resources: a control register and a data port. The control register chooses one peripheral, as a one-hot pattern, and a transfer direction. While a peripheral is chosen, a repeating timer sends a single-cycle non-maskable interrupt pulse to the host. Each pulse tells the host software to move the next byte through the data port, so the timer sets the rate of every transfer.

Data-port writes become a single-cycle write strobe, with the byte, on the chosen peripheral's lane. Data-port reads become a single-cycle read strobe on that lane, and the byte the peripheral presents is returned as a response. A control write that selects reading also sends a read-request pulse, so the peripheral can prepare its first byte. Transfers in the wrong direction, and selections that are not one-hot, never reach any peripheral.

The host data channels use valid/ready. Both ready outputs are held high, so the block never applies back-pressure. Every accepted read request yields exactly one response, a fixed two cycles later. The response has no ready input, so the host must take it in the cycle it appears.

Top module: `nmi_paced_bridge`

## Requirements
- R1: After reset the control readback is 0x00. After a control write, the readback equals the written byte from the next cycle onward.
- R2: A control write whose select field (bits 3:0) is nonzero starts the timer. `nmi` goes high for exactly one cycle, PERIOD_CYC cycles after the write edge, and then again every PERIOD_CYC cycles.
- R3: A control write whose select field is zero stops the timer. `nmi` stays low until a later write with a nonzero select.
- R4: Every control write restarts the timer count from zero. A rewrite before the period ends delays the next pulse to PERIOD_CYC cycles after the rewrite.
- R5: A control write with bit 4 set and a one-hot select makes `pf_rreq_stb` pulse for one cycle on the selected lane (bit k = peripheral k), in the cycle after the write. No other control write produces a request pulse.
- R6: When control bit 4 is 0 and the select is one-hot, an accepted data write drives `pf_wr_stb` high on the selected lane only, for one cycle, in the cycle after the write. During that cycle `pf_wr_data` carries the byte.
- R7: When control bit 4 is 1, a data write is discarded: no write strobe fires.
- R8: When control bit 4 is 1 and the select is one-hot, an accepted data read pulses `pf_rd_stb` on the selected lane in the cycle after the request. The response carries that lane's byte, taken from `pf_rd_data[8k+7:8k]`.
- R9: When control bit 4 is 0, a data read returns 0x00 and no read strobe fires.
- R10: When bit 4 is 1 and the select is not exactly one-hot (including zero), a data read returns 0xFF without a strobe. A data write with any select that is not one-hot fires no strobe.
- R11: Both ready outputs are always high. Every accepted read request gives one response with `dat_rsp_valid` high exactly two cycles after the request cycle, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control byte: bits 3:0 one-hot select, bit 4 read direction |
| ctl_rdata | output | 8 | Current control register value |
| dat_wr_valid | input | 1 | Host data write valid |
| dat_wr_ready | output | 1 | Host data write ready (always high) |
| dat_wdata | input | 8 | Host data write byte |
| dat_rd_valid | input | 1 | Host data read request valid |
| dat_rd_ready | output | 1 | Host data read ready (always high) |
| dat_rsp_valid | output | 1 | Read response valid |
| dat_rsp_data | output | 8 | Read response byte |
| nmi | output | 1 | Single-cycle pacing interrupt pulse |
| pf_wr_stb | output | 4 | Per-peripheral write strobes |
| pf_wr_data | output | 8 | Byte delivered with a write strobe |
| pf_rd_stb | output | 4 | Per-peripheral read strobes |
| pf_rd_data | input | 32 | Per-peripheral read bytes, lane k in bits 8k+7:8k |
| pf_rreq_stb | output | 4 | Per-peripheral read-request pulses |

## Verification
The bench measures the exact distance to the first pacing pulse, and to the one after it, in cycles. It rewrites the control register partway through a period to show that the count restarts; a timer that kept counting would fire early. It drives wrong-direction accesses and multi-bit or empty selections and observes the strobes and the response bytes. A router that checked the select before the direction would return 0xFF instead of 0x00, and one that ignored the direction would leak strobes. Request pulses are checked for both one-hot and malformed read selections, and response timing is checked one cycle early as well as on time.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  localparam int MAX_SEL_W = 8;

  typedef enum logic [1:0] {
    RSP_PERIPH = 2'd0,
    RSP_ZERO   = 2'd1,
    RSP_ONES   = 2'd2
  } rsp_kind_e;

  function automatic logic is_one_hot(input logic [MAX_SEL_W-1:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < MAX_SEL_W; i++) n = n + {3'b000, v[i]};
    return (n == 4'd1);
  endfunction

endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int CTL_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic [CTL_W-1:0]      ctl_wdata,
  output logic [CTL_W-1:0]      ctl_q,
  output logic [NUM_PERIPH-1:0] sel,
  output logic                  rd_dir,
  output logic                  sel_ok,
  output logic                  load,
  output logic                  load_run,
  output logic [NUM_PERIPH-1:0] rreq_stb
);
  localparam int DIR_BIT = NUM_PERIPH;

  logic [NUM_PERIPH-1:0] new_sel;
  logic                  new_ok;

  assign new_sel = ctl_wdata[NUM_PERIPH-1:0];
  assign new_ok  = is_one_hot(MAX_SEL_W'(new_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      rreq_stb <= '0;
    end else begin
      rreq_stb <= '0;
      if (ctl_wr) begin
        ctl_q <= ctl_wdata;
        if (ctl_wdata[DIR_BIT] && new_ok) rreq_stb <= new_sel;
      end
    end
  end

  assign sel      = ctl_q[NUM_PERIPH-1:0];
  assign rd_dir   = ctl_q[DIR_BIT];
  assign sel_ok   = is_one_hot(MAX_SEL_W'(sel));
  assign load     = ctl_wr;
  assign load_run = |new_sel;

endmodule

// File: rtl/bridge_pacer.sv
module bridge_pacer #(
  parameter int PERIOD_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_run,
  output logic nmi
);
  localparam int CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             at_end;

  assign at_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      nmi     <= 1'b0;
    end else if (load) begin
      cnt     <= '0;
      running <= load_run;
      nmi     <= 1'b0;
    end else if (running) begin
      nmi <= at_end;
      cnt <= at_end ? '0 : cnt + 1'b1;
    end else begin
      nmi <= 1'b0;
    end
  end

endmodule

// File: rtl/bridge_router.sv
module bridge_router
  import bridge_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PERIPH-1:0]        sel,
  input  logic                         rd_dir,
  input  logic                         sel_ok,
  input  logic                         wr_valid,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         rd_valid,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_data,
  output logic [NUM_PERIPH-1:0]        wr_stb,
  output logic [DATA_W-1:0]            wr_data,
  output logic [NUM_PERIPH-1:0]        rd_stb,
  input  logic [NUM_PERIPH*DATA_W-1:0] rd_data
);
  logic      rd_pend;
  rsp_kind_e rd_kind;
  rsp_kind_e next_kind;
  logic [DATA_W-1:0] lane_mux;

  always_comb begin
    if (!rd_dir)      next_kind = RSP_ZERO;
    else if (!sel_ok) next_kind = RSP_ONES;
    else              next_kind = RSP_PERIPH;
  end

  always_comb begin
    lane_mux = '0;
    for (int k = 0; k < NUM_PERIPH; k++)
      lane_mux = lane_mux | (rd_data[k*DATA_W +: DATA_W] & {DATA_W{rd_stb[k]}});
  end

  // stage 1: strobes toward the peripherals
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_stb  <= '0;
      wr_data <= '0;
      rd_stb  <= '0;
      rd_pend <= 1'b0;
      rd_kind <= RSP_ZERO;
    end else begin
      wr_stb  <= '0;
      rd_stb  <= '0;
      rd_pend <= rd_valid;
      if (wr_valid && !rd_dir && sel_ok) begin
        wr_stb  <= sel;
        wr_data <= wdata;
      end
      if (rd_valid) begin
        rd_kind <= next_kind;
        if (next_kind == RSP_PERIPH) rd_stb <= sel;
      end
    end
  end

  // stage 2: response back to the host
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_pend;
      if (rd_pend) begin
        unique case (rd_kind)
          RSP_PERIPH: rsp_data <= lane_mux;
          RSP_ONES:   rsp_data <= '1;
          default:    rsp_data <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/nmi_paced_bridge.sv
module nmi_paced_bridge #(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8,
  parameter int PERIOD_CYC = 50000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_wr,
  input  logic [DATA_W-1:0]            ctl_wdata,
  output logic [DATA_W-1:0]            ctl_rdata,
  input  logic                         dat_wr_valid,
  output logic                         dat_wr_ready,
  input  logic [DATA_W-1:0]            dat_wdata,
  input  logic                         dat_rd_valid,
  output logic                         dat_rd_ready,
  output logic                         dat_rsp_valid,
  output logic [DATA_W-1:0]            dat_rsp_data,
  output logic                         nmi,
  output logic [NUM_PERIPH-1:0]        pf_wr_stb,
  output logic [DATA_W-1:0]            pf_wr_data,
  output logic [NUM_PERIPH-1:0]        pf_rd_stb,
  input  logic [NUM_PERIPH*DATA_W-1:0] pf_rd_data,
  output logic [NUM_PERIPH-1:0]        pf_rreq_stb
);
  logic [NUM_PERIPH-1:0] sel;
  logic rd_dir, sel_ok, load, load_run;

  assign dat_wr_ready = 1'b1;
  assign dat_rd_ready = 1'b1;

  bridge_ctrl #(.NUM_PERIPH(NUM_PERIPH), .CTL_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_rdata), .sel(sel), .rd_dir(rd_dir), .sel_ok(sel_ok),
    .load(load), .load_run(load_run), .rreq_stb(pf_rreq_stb)
  );

  bridge_pacer #(.PERIOD_CYC(PERIOD_CYC)) u_pacer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_run(load_run), .nmi(nmi)
  );

  bridge_router #(.NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)) u_router (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_dir(rd_dir), .sel_ok(sel_ok),
    .wr_valid(dat_wr_valid), .wdata(dat_wdata), .rd_valid(dat_rd_valid),
    .rsp_valid(dat_rsp_valid), .rsp_data(dat_rsp_data),
    .wr_stb(pf_wr_stb), .wr_data(pf_wr_data), .rd_stb(pf_rd_stb),
    .rd_data(pf_rd_data)
  );

endmodule

// File: rtl/nmi_paced_bridge_checker.sv
module nmi_paced_bridge_checker #(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ctl_wr,
  input logic [DATA_W-1:0]     ctl_wdata,
  input logic [DATA_W-1:0]     ctl_rdata,
  input logic                  dat_wr_valid,
  input logic                  dat_wr_ready,
  input logic                  dat_rd_valid,
  input logic                  dat_rd_ready,
  input logic                  dat_rsp_valid,
  input logic                  nmi,
  input logic [NUM_PERIPH-1:0] pf_wr_stb,
  input logic [NUM_PERIPH-1:0] pf_rd_stb,
  input logic [NUM_PERIPH-1:0] pf_rreq_stb
);
  localparam int DIR_BIT = NUM_PERIPH;

  p_nmi_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);

  p_nmi_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[NUM_PERIPH-1:0] == '0) |-> !nmi);

  p_rreq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|pf_rreq_stb) |-> ($past(ctl_wr) && $past(ctl_wdata[DIR_BIT])));

  p_rreq_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pf_rreq_stb));

  p_wr_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|pf_wr_stb) |-> ($past(dat_wr_valid) && !$past(ctl_rdata[DIR_BIT])));

  p_wr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pf_wr_stb));

  p_rd_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pf_rd_stb) |-> ($past(dat_rd_valid) && $past(ctl_rdata[DIR_BIT])));

  p_rsp_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rsp_valid |-> $past(dat_rd_valid, 2));

  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_ready && dat_rd_ready);

endmodule

bind nmi_paced_bridge nmi_paced_bridge_checker #(
  .NUM_PERIPH(NUM_PERIPH), .DATA_W(DATA_W)
) u_checker (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .dat_wr_valid(dat_wr_valid),
  .dat_wr_ready(dat_wr_ready), .dat_rd_valid(dat_rd_valid),
  .dat_rd_ready(dat_rd_ready), .dat_rsp_valid(dat_rsp_valid), .nmi(nmi),
  .pf_wr_stb(pf_wr_stb), .pf_rd_stb(pf_rd_stb), .pf_rreq_stb(pf_rreq_stb)
);

// File: tb/nmi_paced_bridge_test.sv
`timescale 1ns/1ps
module nmi_paced_bridge_test;
  localparam int NP  = 4;
  localparam int DW  = 8;
  localparam int PER = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [DW-1:0] ctl_wdata = '0;
  logic [DW-1:0] ctl_rdata;
  logic dat_wr_valid = 1'b0;
  logic dat_wr_ready;
  logic [DW-1:0] dat_wdata = '0;
  logic dat_rd_valid = 1'b0;
  logic dat_rd_ready;
  logic dat_rsp_valid;
  logic [DW-1:0] dat_rsp_data;
  logic nmi;
  logic [NP-1:0] pf_wr_stb, pf_rd_stb, pf_rreq_stb;
  logic [DW-1:0] pf_wr_data;
  logic [NP*DW-1:0] pf_rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] lane_byte(input int k);
    return 8'h5A + 8'(k * 17);
  endfunction

  always_comb
    for (int k = 0; k < NP; k++) pf_rd_data[k*DW +: DW] = lane_byte(k);

  nmi_paced_bridge #(.NUM_PERIPH(NP), .DATA_W(DW), .PERIOD_CYC(PER)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_wr_valid(dat_wr_valid),
    .dat_wr_ready(dat_wr_ready), .dat_wdata(dat_wdata),
    .dat_rd_valid(dat_rd_valid), .dat_rd_ready(dat_rd_ready),
    .dat_rsp_valid(dat_rsp_valid), .dat_rsp_data(dat_rsp_data), .nmi(nmi),
    .pf_wr_stb(pf_wr_stb), .pf_wr_data(pf_wr_data), .pf_rd_stb(pf_rd_stb),
    .pf_rd_data(pf_rd_data), .pf_rreq_stb(pf_rreq_stb)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 100000", cyc);
      finish_run();
    end
  end

  // drive one control write; returns half a cycle after the capturing edge
  task automatic ctl_write(input logic [DW-1:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic data_write(input logic [DW-1:0] d, output logic [NP-1:0] stb,
                            output logic [DW-1:0] bus);
    @(negedge clk);
    dat_wr_valid = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_wr_valid = 1'b0;
    stb = pf_wr_stb; bus = pf_wr_data;
  endtask

  task automatic data_read(output logic [NP-1:0] stb, output logic early_v,
                           output logic v, output logic [DW-1:0] d);
    @(negedge clk);
    dat_rd_valid = 1'b1;
    @(negedge clk);
    dat_rd_valid = 1'b0;
    stb = pf_rd_stb; early_v = dat_rsp_valid;
    @(negedge clk);
    v = dat_rsp_valid; d = dat_rsp_data;
  endtask

  task automatic t_reset();
    check(ctl_rdata == 8'h00, "R1 reset ctl", ctl_rdata, 0);
    check(nmi == 1'b0, "R2 reset nmi", nmi, 0);
    check(pf_wr_stb == '0 && pf_rd_stb == '0 && pf_rreq_stb == '0, "R11 reset strobes", 0, 0);
    check(dat_rsp_valid == 1'b0, "R11 reset rsp", dat_rsp_valid, 0);
    check(dat_wr_ready && dat_rd_ready, "R11 ready", {dat_wr_ready, dat_rd_ready}, 3);
  endtask

  task automatic t_readback();
    ctl_write(8'hE3);
    check(ctl_rdata == 8'hE3, "R1 readback", ctl_rdata, 8'hE3);
    ctl_write(8'h00);
    check(ctl_rdata == 8'h00, "R1 readback zero", ctl_rdata, 0);
  endtask

  task automatic t_rreq();
    ctl_write(8'h12);
    check(pf_rreq_stb == 4'b0010, "R5 rreq lane1", pf_rreq_stb, 4'b0010);
    @(negedge clk);
    check(pf_rreq_stb == 4'b0000, "R5 rreq one cycle", pf_rreq_stb, 0);
    ctl_write(8'h02);
    check(pf_rreq_stb == 4'b0000, "R5 no rreq in write dir", pf_rreq_stb, 0);
    ctl_write(8'h13);
    check(pf_rreq_stb == 4'b0000, "R5 no rreq bad select", pf_rreq_stb, 0);
  endtask

  task automatic t_write_ok();
    logic [NP-1:0] s; logic [DW-1:0] b;
    ctl_write(8'h04);
    data_write(8'hC3, s, b);
    check(s == 4'b0100, "R6 wr strobe", s, 4'b0100);
    check(b == 8'hC3, "R6 wr data", b, 8'hC3);
    @(negedge clk);
    check(pf_wr_stb == '0, "R6 wr strobe one cycle", pf_wr_stb, 0);
  endtask

  task automatic t_write_wrong_dir();
    logic [NP-1:0] s; logic [DW-1:0] b;
    ctl_write(8'h14);
    data_write(8'h77, s, b);
    check(s == '0, "R7 wr discarded", s, 0);
  endtask

  task automatic t_read_ok();
    logic [NP-1:0] s; logic ev, v; logic [DW-1:0] d;
    ctl_write(8'h18);
    data_read(s, ev, v, d);
    check(s == 4'b1000, "R8 rd strobe lane3", s, 4'b1000);
    check(v && d == lane_byte(3), "R8 rd data lane3", d, lane_byte(3));
    check(!ev, "R11 no early rsp", ev, 0);
    ctl_write(8'h11);
    data_read(s, ev, v, d);
    check(s == 4'b0001, "R8 rd strobe lane0", s, 4'b0001);
    check(v && d == lane_byte(0), "R8 rd data lane0", d, lane_byte(0));
    @(negedge clk);
    check(!dat_rsp_valid, "R11 single rsp", dat_rsp_valid, 0);
  endtask

  task automatic t_read_wrong_dir();
    logic [NP-1:0] s; logic ev, v; logic [DW-1:0] d;
    ctl_write(8'h02);
    data_read(s, ev, v, d);
    check(s == '0, "R9 no rd strobe", s, 0);
    check(v && d == 8'h00, "R9 rd zero", d, 0);
    ctl_write(8'h06);
    data_read(s, ev, v, d);
    check(v && d == 8'h00, "R9 rd zero bad select", d, 0);
  endtask

  task automatic t_bad_select();
    logic [NP-1:0] s; logic ev, v; logic [DW-1:0] d; logic [DW-1:0] b;
    ctl_write(8'h16);
    data_read(s, ev, v, d);
    check(s == '0, "R10 no rd strobe multi", s, 0);
    check(v && d == 8'hFF, "R10 rd ones multi", d, 8'hFF);
    ctl_write(8'h10);
    data_read(s, ev, v, d);
    check(v && d == 8'hFF, "R10 rd ones empty", d, 8'hFF);
    ctl_write(8'h05);
    data_write(8'h3E, s, b);
    check(s == '0, "R10 wr ignored multi", s, 0);
  endtask

  task automatic t_nmi_period();
    int n;
    ctl_write(8'h01);
    n = 0;
    do begin @(negedge clk); n++; end while (!nmi && n < 3 * PER);
    check(n == PER, "R2 first nmi delay", n, PER);
    @(negedge clk);
    check(!nmi, "R2 nmi single cycle", nmi, 0);
    n = 1;
    do begin @(negedge clk); n++; end while (!nmi && n < 3 * PER);
    check(n == PER, "R2 nmi repeat", n, PER);
  endtask

  task automatic t_nmi_restart();
    int n; int seen;
    ctl_write(8'h02);
    seen = 0;
    for (int i = 0; i < PER / 2; i++) begin @(negedge clk); seen += int'(nmi); end
    ctl_write(8'h02);
    n = 0;
    do begin @(negedge clk); n++; seen += int'(nmi && n < PER); end
      while (!nmi && n < 3 * PER);
    check(n == PER, "R4 restart delay", n, PER);
    check(seen == 0, "R4 no early pulse", seen, 0);
  endtask

  task automatic t_nmi_stop();
    int seen;
    ctl_write(8'h00);
    seen = 0;
    for (int i = 0; i < 3 * PER; i++) begin @(negedge clk); seen += int'(nmi); end
    check(seen == 0, "R3 nmi stopped", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_rreq();
    t_write_ok();
    t_write_wrong_dir();
    t_read_ok();
    t_read_wrong_dir();
    t_bad_select();
    t_nmi_period();
    t_nmi_restart();
    t_nmi_stop();
    finish_run();
  end

endmodule